// File: doc/BRIEF.md
# Translation Cache Refill Controller

This block holds the contents of a fully associative address-translation cache and the small set of control registers that feed it. Software-visible stores reach it through one write port that carries an operation code, an address and a 64-bit payload. A store can update a control register, place a new translation into the cache automatically, or overwrite one chosen cache slot directly. Every cache slot is a pair of 64-bit words: a tag, which is always taken from the staged tag register, and a data word, which is taken from the store payload.

Automatic placement searches in two passes within the store cycle. It first takes the lowest-numbered slot that holds no valid translation. If no such slot exists, it takes the lowest-numbered slot that is not pinned. When every slot is both valid and pinned, the store is dropped and a one-cycle failure pulse is raised. A combinational read port returns any tag, data word or register, so that the result of each store can be observed.

Top module: `tlb_fill_ctrl`

## Requirements
- R1: After reset every tag word, every data word and every register reads as zero, so all slots are invalid, and `insert_fail` is low.
- R2: A store with `wr_op`=0 writes `wr_data` into register `wr_addr[6:3]`. The new value is readable on the port with `rd_sel`=2 from the next cycle on.
- R3: A store with `wr_op`=1 writes the lowest-numbered slot whose data bit 63 (valid) is 0.
- R4: When every slot is valid, a store with `wr_op`=1 writes the lowest-numbered slot whose data bit 6 (pin) is 0.
- R5: When every slot is valid and pinned, a store with `wr_op`=1 leaves every slot unchanged. `insert_fail` is then high for exactly the following cycle.
- R6: Register stores to index 0 or index 4 change nothing.
- R7: A register store to index 3 with `wr_data[0]`=0 clears both register 3 and register 4. With `wr_data[0]`=1 the payload is stored in register 3.
- R8: Every slot write stores register 6 as the tag and `wr_data` as the data word.
- R9: A store with `wr_op`=2 writes slot `wr_addr[8:3]`, whatever its valid and pin bits are.
- R10: A store with `wr_op`=3 changes no slot and no register. Reads select by `rd_sel`: 0 returns the tag of slot `rd_idx`, 1 returns the data word of slot `rd_idx`, 2 returns register `rd_idx[3:0]`, and 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Store strobe |
| wr_op | input | 2 | Store kind: 0 register, 1 automatic placement, 2 direct slot, 3 no-op |
| wr_addr | input | 16 | Store address; bits [6:3] pick a register, bits [8:3] pick a slot |
| wr_data | input | 64 | Store payload |
| rd_sel | input | 2 | Read source: 0 tag, 1 data, 2 register, 3 zero |
| rd_idx | input | 6 | Slot number, or register number in the low 4 bits |
| rd_data | output | 64 | Read result, combinational |
| insert_fail | output | 1 | One-cycle pulse after a placement that found no slot |

## Verification
The assertions assume that `wr_op` and `wr_addr` are stable and known whenever `wr_en` is high, and that `wr_data` bit 63 and bit 6 carry meaningful valid and pin flags on placement stores. The bench drives every store on the falling clock edge, holds it for a single cycle, and then returns `wr_en` to low. It loads tags through register 6 before each placement, so the staged value is always defined at the moment an assertion looks at the slot just written. It builds the full-and-pinned case deliberately, by filling all 64 slots with only two of them unpinned, so the no-slot branch is reached through ordinary stores.

// File: rtl/tlbf_pkg.sv
package tlbf_pkg;
   typedef enum logic [1:0] {
      OP_REG_WR  = 2'd0,
      OP_INSERT  = 2'd1,
      OP_INDEXED = 2'd2,
      OP_NOP     = 2'd3
   } tlbf_op_e;

   typedef enum logic [1:0] {
      RD_TAG  = 2'd0,
      RD_DATA = 2'd1,
      RD_REG  = 2'd2,
      RD_NONE = 2'd3
   } tlbf_rd_e;
endpackage

// File: rtl/tlbf_prio_enc.sv
module tlbf_prio_enc #(
   parameter int N = 64,
   localparam int W = $clog2(N)
) (
   input  logic [N-1:0] req,
   output logic         found,
   output logic [W-1:0] idx
);
   // lowest set bit wins: scan downward so the last hit is the smallest index
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            found = 1'b1;
            idx   = W'(i);
         end
      end
   end
endmodule

// File: rtl/tlbf_victim_sel.sv
module tlbf_victim_sel #(
   parameter int N           = 64,
   parameter bit ALLOW_EVICT = 1'b1,
   localparam int W = $clog2(N)
) (
   input  logic [N-1:0] valid_vec,
   input  logic [N-1:0] lock_vec,
   output logic         found,
   output logic [W-1:0] idx
);
   logic         free_hit;
   logic [W-1:0] free_idx;

   tlbf_prio_enc #(.N(N)) i_free (
      .req   (~valid_vec),
      .found (free_hit),
      .idx   (free_idx)
   );

   generate
      if (ALLOW_EVICT) begin : g_two_pass
         logic         evict_hit;
         logic [W-1:0] evict_idx;
         tlbf_prio_enc #(.N(N)) i_evict (
            .req   (~lock_vec),
            .found (evict_hit),
            .idx   (evict_idx)
         );
         assign found = free_hit | evict_hit;
         assign idx   = free_hit ? free_idx : evict_idx;
      end else begin : g_free_only
         assign found = free_hit;
         assign idx   = free_idx;
      end
   endgenerate
endmodule

// File: rtl/tlbf_regbank.sv
module tlbf_regbank #(
   parameter int NREG    = 16,
   parameter int W       = 64,
   parameter int RO_IDX  = 0,
   parameter int FSR_IDX = 3,
   parameter int FAR_IDX = 4,
   parameter int TAG_IDX = 6,
   localparam int RW = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [RW-1:0] widx,
   input  logic [W-1:0]  wdata,
   input  logic [RW-1:0] rd_idx,
   output logic [W-1:0]  rd_q,
   output logic [W-1:0]  tag_stage
);
   logic [W-1:0] q [NREG];
   logic         clr_fault;

   assign clr_fault = we && (widx == RW'(FSR_IDX)) && !wdata[0];

   generate
      for (genvar r = 0; r < NREG; r++) begin : g_reg
         if (r == RO_IDX || r == FAR_IDX) begin : g_guarded
            // no store path; the fault address only ever clears
            always_ff @(posedge clk) begin
               if (!rst_n)                        q[r] <= '0;
               else if (clr_fault && r == FAR_IDX) q[r] <= '0;
            end
         end else begin : g_plain
            always_ff @(posedge clk) begin
               if (!rst_n)                         q[r] <= '0;
               else if (clr_fault && r == FSR_IDX) q[r] <= '0;
               else if (we && widx == RW'(r))      q[r] <= wdata;
            end
         end
      end
   endgenerate

   assign rd_q      = q[rd_idx];
   assign tag_stage = q[TAG_IDX];

   a_r6_ro_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (we && widx == RW'(RO_IDX)) |=> (q[RO_IDX] == $past(q[RO_IDX])));

   a_r7_fault_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (we && widx == RW'(FSR_IDX) && !wdata[0]) |=> (q[FSR_IDX] == '0 && q[FAR_IDX] == '0));
endmodule

// File: rtl/tlbf_entry_array.sv
module tlbf_entry_array #(
   parameter int N         = 64,
   parameter int W         = 64,
   parameter int VALID_BIT = 63,
   parameter int LOCK_BIT  = 6,
   localparam int IW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [IW-1:0] widx,
   input  logic [W-1:0]  wtag,
   input  logic [W-1:0]  wdata,
   input  logic [IW-1:0] rd_idx,
   output logic [W-1:0]  rd_tag,
   output logic [W-1:0]  rd_data,
   output logic [N-1:0]  valid_vec,
   output logic [N-1:0]  lock_vec
);
   logic [W-1:0] tag_q  [N];
   logic [W-1:0] data_q [N];

   generate
      for (genvar e = 0; e < N; e++) begin : g_slot
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               tag_q[e]  <= '0;
               data_q[e] <= '0;
            end else if (we && widx == IW'(e)) begin
               tag_q[e]  <= wtag;
               data_q[e] <= wdata;
            end
         end
         assign valid_vec[e] = data_q[e][VALID_BIT];
         assign lock_vec[e]  = data_q[e][LOCK_BIT];
      end
   endgenerate

   assign rd_tag  = tag_q[rd_idx];
   assign rd_data = data_q[rd_idx];

   // slot-number copy kept only for the check below
   logic [IW-1:0] last_idx;
   always_ff @(posedge clk) last_idx <= widx;

   a_r8_slot_written: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (tag_q[last_idx] == $past(wtag) && data_q[last_idx] == $past(wdata)));
endmodule

// File: rtl/tlb_fill_ctrl.sv
module tlb_fill_ctrl
   import tlbf_pkg::*;
#(
   parameter int ENTRIES   = 64,
   parameter int NREG      = 16,
   parameter int DATA_W    = 64,
   parameter int ADDR_W    = 16,
   parameter int SLOT_LSB  = 3,
   parameter int VALID_BIT = 63,
   parameter int LOCK_BIT  = 6,
   parameter bit EVICT_EN  = 1'b1,
   localparam int IDX_W  = $clog2(ENTRIES),
   localparam int RIDX_W = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_op,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [1:0]        rd_sel,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   output logic              insert_fail
);
   // elaboration-time parameter checks
   if (VALID_BIT >= DATA_W || LOCK_BIT >= DATA_W) begin : g_bad_bits
      $error("flag bit positions exceed the data width");
   end
   if (ADDR_W <= SLOT_LSB + IDX_W || IDX_W < RIDX_W) begin : g_bad_addr
      $error("address field does not cover slot and register indices");
   end
   if ((1 << IDX_W) != ENTRIES || NREG < 7) begin : g_bad_depth
      $error("entry count must be a power of two and at least 7 registers exist");
   end

   tlbf_op_e            op;
   logic                reg_we, ins_req, ent_we;
   logic [IDX_W-1:0]    slot_addr, ent_idx, vidx;
   logic [RIDX_W-1:0]   reg_addr;
   logic                vfound;
   logic [ENTRIES-1:0]  valid_vec, lock_vec;
   logic [DATA_W-1:0]   tag_stage, reg_q, ent_tag, ent_data;
   logic                unused_addr;

   assign op          = tlbf_op_e'(wr_op);
   assign slot_addr   = wr_addr[SLOT_LSB +: IDX_W];
   assign reg_addr    = wr_addr[SLOT_LSB +: RIDX_W];
   assign unused_addr = ^{wr_addr[SLOT_LSB-1:0], wr_addr[ADDR_W-1:SLOT_LSB+IDX_W]};

   assign reg_we  = wr_en && (op == OP_REG_WR);
   assign ins_req = wr_en && (op == OP_INSERT);
   assign ent_we  = (wr_en && op == OP_INDEXED) || (ins_req && vfound);
   assign ent_idx = (op == OP_INDEXED) ? slot_addr : vidx;

   tlbf_victim_sel #(.N(ENTRIES), .ALLOW_EVICT(EVICT_EN)) i_victim (
      .valid_vec (valid_vec),
      .lock_vec  (lock_vec),
      .found     (vfound),
      .idx       (vidx)
   );

   tlbf_regbank #(.NREG(NREG), .W(DATA_W)) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (reg_we),
      .widx      (reg_addr),
      .wdata     (wr_data),
      .rd_idx    (rd_idx[RIDX_W-1:0]),
      .rd_q      (reg_q),
      .tag_stage (tag_stage)
   );

   tlbf_entry_array #(.N(ENTRIES), .W(DATA_W), .VALID_BIT(VALID_BIT), .LOCK_BIT(LOCK_BIT)) i_array (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (ent_we),
      .widx      (ent_idx),
      .wtag      (tag_stage),
      .wdata     (wr_data),
      .rd_idx    (rd_idx),
      .rd_tag    (ent_tag),
      .rd_data   (ent_data),
      .valid_vec (valid_vec),
      .lock_vec  (lock_vec)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) insert_fail <= 1'b0;
      else        insert_fail <= ins_req && !vfound;
   end

   always_comb begin
      case (tlbf_rd_e'(rd_sel))
         RD_TAG:  rd_data = ent_tag;
         RD_DATA: rd_data = ent_data;
         RD_REG:  rd_data = reg_q;
         default: rd_data = '0;
      endcase
   end

   a_r3_pick_free: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_req && !(&valid_vec)) |-> (vfound && !valid_vec[vidx]));

   a_r4_pick_unpinned: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_req && (&valid_vec) && vfound) |-> !lock_vec[vidx]);

   a_r5_fail_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_req && !vfound) |=> insert_fail);

   a_r5_fail_cause: assert property (@(posedge clk) disable iff (!rst_n)
      insert_fail |-> $past(ins_req && !vfound));
endmodule

// File: tb/test_tlb_fill_ctrl.sv
module test_tlb_fill_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_op = 2'd3;
   logic [15:0] wr_addr = '0;
   logic [63:0] wr_data = '0;
   logic [1:0]  rd_sel = 2'd3;
   logic [5:0]  rd_idx = '0;
   logic [63:0] rd_data;
   logic        insert_fail;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [63:0] m_tag [64];
   logic [63:0] m_dat [64];
   logic [63:0] m_reg [16];

   always #2 clk = ~clk;

   tlb_fill_ctrl i_tlb_fill_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_op(wr_op), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_sel(rd_sel), .rd_idx(rd_idx), .rd_data(rd_data),
      .insert_fail(insert_fail)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [1:0] sel, input int idx, output logic [63:0] v);
      rd_sel = sel;
      rd_idx = 6'(idx);
      #1;
      v = rd_data;
   endtask

   task automatic store(input logic [1:0] op, input logic [15:0] addr, input logic [63:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_op = op; wr_addr = addr; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_op = 2'd3;
   endtask

   function automatic int pick_slot();
      for (int i = 0; i < 64; i++) if (!m_dat[i][63]) return i;
      for (int i = 0; i < 64; i++) if (!m_dat[i][6]) return i;
      return -1;
   endfunction

   function automatic logic [63:0] mk(input int i, input bit pin);
      return 64'h8000_0000_0000_0001 | (64'(i) << 8) | (pin ? 64'h40 : 64'h0);
   endfunction

   task automatic reg_store(input int r, input logic [63:0] d);
      store(2'd0, 16'(r << 3), d);
      if (r == 3 && !d[0]) begin m_reg[3] = '0; m_reg[4] = '0; end
      else if (r != 0 && r != 4) m_reg[r] = d;
   endtask

   // placement with model update; checks the slot chosen and the fail pulse
   task automatic place(input string req, input logic [63:0] d);
      logic [63:0] v;
      int s;
      s = pick_slot();
      store(2'd1, 16'h0, d);
      if (s >= 0) begin
         m_tag[s] = m_reg[6]; m_dat[s] = d;
         rd(2'd1, s, v); chk({req, " data"}, v, d);
         rd(2'd0, s, v); chk({req, " R8 tag"}, v, m_reg[6]);
         chk({req, " no fail"}, 64'(insert_fail), 64'h0);
      end else begin
         chk("R5 fail high", 64'(insert_fail), 64'h1);
         for (int i = 0; i < 64; i++) begin
            rd(2'd1, i, v);
            if (v !== m_dat[i]) chk("R5 slot untouched", v, m_dat[i]);
         end
         n_chk++;
         @(negedge clk);
         chk("R5 fail one cycle", 64'(insert_fail), 64'h0);
      end
   endtask

   task automatic t_reset();
      logic [63:0] v;
      for (int i = 0; i < 16; i++) begin rd(2'd2, i, v); chk("R1 reg zero", v, 64'h0); end
      for (int i = 0; i < 64; i += 9) begin
         rd(2'd1, i, v); chk("R1 data zero", v, 64'h0);
         rd(2'd0, i, v); chk("R1 tag zero", v, 64'h0);
      end
      chk("R1 fail low", 64'(insert_fail), 64'h0);
   endtask

   task automatic t_regs();
      logic [63:0] v;
      reg_store(1, 64'h1111_2222_3333_4444);
      rd(2'd2, 1, v); chk("R2 reg1", v, 64'h1111_2222_3333_4444);
      reg_store(15, 64'hFEDC_BA98_7654_3210);
      rd(2'd2, 15, v); chk("R2 reg15", v, 64'hFEDC_BA98_7654_3210);
      reg_store(0, 64'hDEAD);
      rd(2'd2, 0, v); chk("R6 reg0 ignored", v, 64'h0);
      reg_store(4, 64'hBEEF);
      rd(2'd2, 4, v); chk("R6 reg4 ignored", v, 64'h0);
      reg_store(3, 64'h55);
      rd(2'd2, 3, v); chk("R7 fsr kept", v, 64'h55);
      reg_store(3, 64'hFFFF_FFFE);
      rd(2'd2, 3, v); chk("R7 fsr cleared", v, 64'h0);
      rd(2'd2, 4, v); chk("R7 far cleared", v, 64'h0);
      rd(2'd3, 1, v); chk("R10 zero select", v, 64'h0);
   endtask

   task automatic t_fill();
      for (int i = 0; i < 64; i++) begin
         reg_store(6, 64'hA5A5_0000_0000_0000 | 64'(i));
         place("R3 free slot", mk(i, !(i == 10 || i == 40)));
      end
   endtask

   task automatic t_evict();
      reg_store(6, 64'hC0DE_0000_0000_0010);
      place("R4 first unpinned", mk(100, 1'b1));
      reg_store(6, 64'hC0DE_0000_0000_0040);
      place("R4 second unpinned", mk(101, 1'b1));
      place("R5 full", mk(102, 1'b0));
   endtask

   task automatic t_indexed();
      logic [63:0] v;
      reg_store(6, 64'h7777_0000_0000_0005);
      store(2'd2, 16'(5 << 3), 64'h0000_0000_0000_0ABC);
      m_tag[5] = m_reg[6]; m_dat[5] = 64'h0ABC;
      rd(2'd1, 5, v); chk("R9 direct data", v, 64'h0ABC);
      rd(2'd0, 5, v); chk("R9 R8 direct tag", v, 64'h7777_0000_0000_0005);
      reg_store(6, 64'h9999);
      place("R3 refill invalidated", mk(200, 1'b1));
      rd(2'd1, 5, v); chk("R3 went to slot 5", v, mk(200, 1'b1));
   endtask

   task automatic t_nop();
      logic [63:0] v;
      store(2'd3, 16'(1 << 3), 64'h0BAD_0BAD);
      rd(2'd2, 1, v); chk("R10 nop reg", v, m_reg[1]);
      rd(2'd1, 1, v); chk("R10 nop slot", v, m_dat[1]);
      chk("R10 nop fail low", 64'(insert_fail), 64'h0);
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      for (int i = 0; i < 64; i++) begin m_tag[i] = '0; m_dat[i] = '0; end
      for (int i = 0; i < 16; i++) m_reg[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_fill();
      t_evict();
      t_indexed();
      t_nop();
      done = 1'b1;
      report();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         report();
      end
   end
endmodule